// File: doc/BRIEF.md
# Dual-Channel Disk Interface Address Router

This block sits between a programmed-I/O request port and the register files of a two-channel disk interface. Each request address is matched against five relocatable windows: the command and control windows of each channel, and a shared bus-master window. The block works out which register block is addressed, which channel it belongs to and the offset inside the window. It then either forwards the access to a per-drive register port or to the bus-master register port, or completes it locally.

The block keeps one drive-select bit per channel. It snoops that bit from byte writes to the drive/head register, so that each channel has a master and a slave drive (drive index 0 to 3). It also enforces the legal access sizes. A 32-bit access to the data port is split into two 16-bit drive accesses. Window bases and the two enables are loaded through a small configuration write port that mirrors base-address and command-register writes.

Top module: `ide_addr_router`

## Requirements
- R1: Windows are matched in a fixed priority, highest first: primary command (span CMD_SPAN), primary control (CTL_SPAN), secondary command, secondary control, bus-master (BM_SPAN). When windows overlap, the access goes to the highest-priority window that matches.
- R2: An address outside all five windows sets the sticky `err_flag`, whatever the enables are. It completes one cycle after acceptance with `rsp_rdata` = 0 and no downstream access. `err_flag` then stays set until reset.
- R3: In the bus-master window, a window offset below BM_SEC_OFS (default 8) is sent with `bm_chan`=0. Any other offset is sent with `bm_chan`=1. `bm_offset` is the window-relative offset.
- R4: A configuration write with `cfg_sel` 0..4 loads the base of window 0..4, in the priority order of R1. It does so only when `cfg_wdata` is nonzero; a zero write leaves the base unchanged. All bases reset to 0.
- R5: A configuration write with `cfg_sel`=5 is a command-register write. Bit 0 sets the I/O enable and bit 2 sets the bus-master enable. Both are reloaded on every such write, and both reset to 0.
- R6: While I/O is disabled, every mapped access completes one cycle after acceptance with read data 0. It causes no downstream access, no drive-select change and no error.
- R7: While bus-master is disabled, writes to the bus-master window complete locally without `bm_valid`. Reads of that window are still forwarded.
- R8: A legal byte write to command offset SEL_OFS (default 6) latches bit SEL_BIT (default 4) of the write data as that channel's device bit. The drive index is 2 × channel + device bit, and that write already uses the new bit.
- R9: The data port (command offset 0) takes 16-bit (`req_size`=1) and 32-bit (`req_size`=2) accesses. A 32-bit access is issued as two back-to-back drive accesses, low half first. The read result is {second half, first half}.
- R10: Every other command or control register accepts only byte accesses (`req_size`=0). The bus-master window accepts sizes 0..2. An illegal size with I/O enabled sets `err_flag` and completes locally with read data 0.
- R11: An access aimed at a drive whose `drv_present` bit is 0 is not forwarded. A read returns 0, a write is dropped, and no error is raised.
- R12: `req_ready` is high only when idle. Local completion responds 1 cycle after acceptance, a single forwarded access responds 2 cycles after, and a split data access 3 cycles after. A byte drive read returns the low 8 bits zero-extended, and writes respond with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | 0..4 window base, 5 command register |
| cfg_wdata | input | AW | Configuration write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Router idle, request accepted |
| req_write | input | 1 | 1 = write |
| req_addr | input | AW | I/O address |
| req_size | input | 2 | 0 byte, 1 half, 2 word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data |
| err_flag | output | 1 | Sticky decode/size error |
| drv_present | input | 4 | Drive attached, by drive index |
| drv_valid | output | 1 | Drive register access |
| drv_write | output | 1 | Drive access is a write |
| drv_idx | output | 2 | Drive index |
| drv_ctrl | output | 1 | 1 = control block, 0 = command block |
| drv_offset | output | OW | Window-relative register offset |
| drv_wdata | output | 16 | Drive write data |
| drv_rdata | input | 16 | Drive read data, valid while drv_valid |
| bm_valid | output | 1 | Bus-master register access |
| bm_write | output | 1 | Bus-master access is a write |
| bm_chan | output | 1 | Channel selected by offset |
| bm_offset | output | OW | Offset in bus-master window |
| bm_size | output | 2 | Access size |
| bm_wdata | output | 32 | Bus-master write data |
| bm_rdata | input | 32 | Bus-master read data, valid while bm_valid |

## Verification
The bench goes after overlapping windows. A router with the wrong priority would send the access to the control block or to the wrong offset. It checks the bus-master channel split on both sides of the secondary offset. A wrong comparison would give a stray `bm_chan`. It covers the device-select write, including the case where that same write is forwarded to the freshly selected drive and the case where it is dropped because I/O is off. A design that used the stale bit, or latched while disabled, would route later data accesses to the wrong drive. Split 32-bit data reads and writes are compared half by half. Swapped halves or a missing second beat show up in the drive fields or in the assembled read value. Absent drives, zero base writes and illegal sizes confirm that nothing leaks downstream and that the error flag rises only where expected.

// File: rtl/ide_rt_pkg.sv
package ide_rt_pkg;
  localparam int NUM_WIN = 5;
  localparam int NUM_CH  = 2;
  localparam int NUM_DRV = 2 * NUM_CH;

  typedef enum logic [2:0] {
    WIN_PCMD = 3'd0,
    WIN_PCTL = 3'd1,
    WIN_SCMD = 3'd2,
    WIN_SCTL = 3'd3,
    WIN_BM   = 3'd4,
    WIN_NONE = 3'd5
  } win_e;

  typedef enum logic [1:0] {
    ACT_LOCAL = 2'd0,
    ACT_BM    = 2'd1,
    ACT_DRV   = 2'd2
  } act_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BM   = 2'd1,
    ST_LO   = 2'd2,
    ST_HI   = 2'd3
  } st_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [2:0] CFG_CMD = 3'd5;
endpackage

// File: rtl/ide_rt_windows.sv
module ide_rt_windows
  import ide_rt_pkg::*;
#(
  parameter int AW       = 16,
  parameter int CMD_SPAN = 8,
  parameter int CTL_SPAN = 4,
  parameter int BM_SPAN  = 16,
  parameter int OW       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic [AW-1:0] addr,
  output logic          io_en,
  output logic          bm_en,
  output win_e          win,
  output logic [OW-1:0] offset
);
  logic [NUM_WIN-1:0][AW-1:0] base_q;
  logic [NUM_WIN-1:0][AW-1:0] rel;
  logic [NUM_WIN-1:0]         hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      io_en  <= 1'b0;
      bm_en  <= 1'b0;
    end else if (cfg_wr) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (cfg_sel == 3'(i) && cfg_wdata != '0) base_q[i] <= cfg_wdata;
      end
      if (cfg_sel == CFG_CMD) begin
        io_en <= cfg_wdata[0];
        bm_en <= cfg_wdata[2];
      end
    end
  end

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    localparam int SPAN = (gi == NUM_WIN - 1) ? BM_SPAN :
                          ((gi % 2) == 1)     ? CTL_SPAN : CMD_SPAN;
    assign rel[gi] = addr - base_q[gi];
    assign hit[gi] = (addr >= base_q[gi]) && (rel[gi] < AW'(SPAN));
  end

  always_comb begin
    win    = WIN_NONE;
    offset = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit[i]) begin
        win    = win_e'(i);
        offset = rel[i][OW-1:0];
      end
    end
  end
endmodule

// File: rtl/ide_rt_devsel.sv
module ide_rt_devsel
  import ide_rt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic set_en,
  input  logic set_val,
  input  logic chan,
  output logic dev_eff
);
  logic [NUM_CH-1:0] dev_q;

  always_ff @(posedge clk) begin
    if (rst) dev_q <= '0;
    else if (set_en) dev_q[chan] <= set_val;
  end

  assign dev_eff = set_en ? set_val : dev_q[chan];
endmodule

// File: rtl/ide_rt_seq.sv
module ide_rt_seq
  import ide_rt_pkg::*;
#(
  parameter int OW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  act_e          act,
  input  logic          err_ev,
  input  logic          split,
  input  logic          byte_acc,
  input  logic          wr,
  input  logic [1:0]    idx,
  input  logic          chan,
  input  logic          ctrl,
  input  logic [OW-1:0] offset,
  input  logic [1:0]    size,
  input  logic [31:0]   wdata,
  output logic          ready,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata,
  output logic          err_flag,
  output logic          drv_valid,
  output logic          drv_write,
  output logic [1:0]    drv_idx,
  output logic          drv_ctrl,
  output logic [OW-1:0] drv_offset,
  output logic [15:0]   drv_wdata,
  input  logic [15:0]   drv_rdata,
  output logic          bm_valid,
  output logic          bm_write,
  output logic          bm_chan,
  output logic [OW-1:0] bm_offset,
  output logic [1:0]    bm_size,
  output logic [31:0]   bm_wdata,
  input  logic [31:0]   bm_rdata
);
  st_e         st;
  logic        split_q, byte_q;
  logic [15:0] hi_q, lo_q;

  assign ready = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      err_flag <= 1'b0;
      drv_valid <= 1'b0;
      drv_write <= 1'b0;
      drv_idx <= '0;
      drv_ctrl <= 1'b0;
      drv_offset <= '0;
      drv_wdata <= '0;
      bm_valid <= 1'b0;
      bm_write <= 1'b0;
      bm_chan <= 1'b0;
      bm_offset <= '0;
      bm_size <= '0;
      bm_wdata <= '0;
      split_q <= 1'b0;
      byte_q <= 1'b0;
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            if (err_ev) err_flag <= 1'b1;
            case (act)
              ACT_BM: begin
                bm_valid  <= 1'b1;
                bm_write  <= wr;
                bm_chan   <= chan;
                bm_offset <= offset;
                bm_size   <= size;
                bm_wdata  <= wdata;
                st        <= ST_BM;
              end
              ACT_DRV: begin
                drv_valid  <= 1'b1;
                drv_write  <= wr;
                drv_idx    <= idx;
                drv_ctrl   <= ctrl;
                drv_offset <= offset;
                drv_wdata  <= byte_acc ? {8'h00, wdata[7:0]} : wdata[15:0];
                hi_q       <= wdata[31:16];
                split_q    <= split;
                byte_q     <= byte_acc;
                st         <= ST_LO;
              end
              default: begin
                rsp_valid <= 1'b1;
                rsp_rdata <= '0;
              end
            endcase
          end
        end
        ST_BM: begin
          bm_valid  <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_rdata <= bm_write ? 32'h0 : bm_rdata;
          st        <= ST_IDLE;
        end
        ST_LO: begin
          if (split_q) begin
            lo_q      <= drv_rdata;
            drv_wdata <= hi_q;
            st        <= ST_HI;
          end else begin
            drv_valid <= 1'b0;
            rsp_valid <= 1'b1;
            if (drv_write)   rsp_rdata <= '0;
            else if (byte_q) rsp_rdata <= {24'h0, drv_rdata[7:0]};
            else             rsp_rdata <= {16'h0, drv_rdata};
            st        <= ST_IDLE;
          end
        end
        default: begin
          drv_valid <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_rdata <= drv_write ? 32'h0 : {drv_rdata, lo_q};
          st        <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/ide_addr_router.sv
module ide_addr_router
  import ide_rt_pkg::*;
#(
  parameter int AW         = 16,
  parameter int CMD_SPAN   = 8,
  parameter int CTL_SPAN   = 4,
  parameter int BM_SPAN    = 16,
  parameter int BM_SEC_OFS = 8,
  parameter int DATA_OFS   = 0,
  parameter int SEL_OFS    = 6,
  parameter int SEL_BIT    = 4,
  localparam int OW        = $clog2(BM_SPAN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata,
  output logic          err_flag,
  input  logic [3:0]    drv_present,
  output logic          drv_valid,
  output logic          drv_write,
  output logic [1:0]    drv_idx,
  output logic          drv_ctrl,
  output logic [OW-1:0] drv_offset,
  output logic [15:0]   drv_wdata,
  input  logic [15:0]   drv_rdata,
  output logic          bm_valid,
  output logic          bm_write,
  output logic          bm_chan,
  output logic [OW-1:0] bm_offset,
  output logic [1:0]    bm_size,
  output logic [31:0]   bm_wdata,
  input  logic [31:0]   bm_rdata
);
  logic          io_en_w, bm_en_w;
  win_e          win;
  logic [OW-1:0] offset;
  logic          is_cmd, is_ctl, is_bm, unmapped, chan;
  logic          data_port, size_ok, sel_wr, dev_eff, present;
  logic          accept, err_ev, local_done, split;
  logic [1:0]    idx;
  act_e          act;

  ide_rt_windows #(
    .AW(AW), .CMD_SPAN(CMD_SPAN), .CTL_SPAN(CTL_SPAN),
    .BM_SPAN(BM_SPAN), .OW(OW)
  ) u_windows (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .addr(req_addr), .io_en(io_en_w),
    .bm_en(bm_en_w), .win(win), .offset(offset)
  );

  assign is_cmd    = (win == WIN_PCMD) || (win == WIN_SCMD);
  assign is_ctl    = (win == WIN_PCTL) || (win == WIN_SCTL);
  assign is_bm     = (win == WIN_BM);
  assign unmapped  = (win == WIN_NONE);
  assign chan      = (win == WIN_SCMD) || (win == WIN_SCTL) ||
                     (is_bm && (offset >= OW'(BM_SEC_OFS)));
  assign data_port = is_cmd && (offset == OW'(DATA_OFS));
  assign size_ok   = is_bm     ? (req_size != 2'd3) :
                     data_port ? ((req_size == SZ_HALF) || (req_size == SZ_WORD)) :
                                 (req_size == SZ_BYTE);
  assign accept    = req_valid && req_ready;
  assign sel_wr    = accept && io_en_w && is_cmd && req_write && size_ok &&
                     (offset == OW'(SEL_OFS));

  ide_rt_devsel u_devsel (
    .clk(clk), .rst(rst), .set_en(sel_wr), .set_val(req_wdata[SEL_BIT]),
    .chan(chan), .dev_eff(dev_eff)
  );

  assign idx        = {chan, dev_eff};
  assign present    = drv_present[idx];
  assign split      = data_port && (req_size == SZ_WORD);
  assign err_ev     = unmapped || (io_en_w && !size_ok);
  assign local_done = unmapped || !io_en_w || !size_ok ||
                      (is_bm && req_write && !bm_en_w) ||
                      ((is_cmd || is_ctl) && !present);
  assign act        = local_done ? ACT_LOCAL : (is_bm ? ACT_BM : ACT_DRV);

  ide_rt_seq #(.OW(OW)) u_seq (
    .clk(clk), .rst(rst), .accept(accept), .act(act), .err_ev(err_ev),
    .split(split), .byte_acc(req_size == SZ_BYTE), .wr(req_write),
    .idx(idx), .chan(chan), .ctrl(is_ctl), .offset(offset),
    .size(req_size), .wdata(req_wdata), .ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err_flag(err_flag),
    .drv_valid(drv_valid), .drv_write(drv_write), .drv_idx(drv_idx),
    .drv_ctrl(drv_ctrl), .drv_offset(drv_offset), .drv_wdata(drv_wdata),
    .drv_rdata(drv_rdata), .bm_valid(bm_valid), .bm_write(bm_write),
    .bm_chan(bm_chan), .bm_offset(bm_offset), .bm_size(bm_size),
    .bm_wdata(bm_wdata), .bm_rdata(bm_rdata)
  );
endmodule

// File: rtl/ide_addr_router_chk.sv
module ide_addr_router_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic       err_flag,
  input logic       drv_valid,
  input logic [1:0] drv_idx,
  input logic [3:0] drv_present,
  input logic       bm_valid,
  input logic       bm_write,
  input logic       bm_en
);
  a_r2_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

  a_r2_err_zero_rsp: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> (rsp_valid && rsp_rdata == 32'h0));

  a_r11_drive_present: assert property (@(posedge clk) disable iff (rst)
    drv_valid |-> drv_present[drv_idx]);

  a_r7_bm_write_gate: assert property (@(posedge clk) disable iff (rst)
    (bm_valid && bm_write) |-> bm_en);

  a_r12_one_target: assert property (@(posedge clk) disable iff (rst)
    !(drv_valid && bm_valid));

  a_r12_busy_while_forward: assert property (@(posedge clk) disable iff (rst)
    (drv_valid || bm_valid) |-> !req_ready);
endmodule

bind ide_addr_router ide_addr_router_chk u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .err_flag(err_flag), .drv_valid(drv_valid),
  .drv_idx(drv_idx), .drv_present(drv_present), .bm_valid(bm_valid),
  .bm_write(bm_write), .bm_en(bm_en_w)
);

// File: tb/ide_addr_router_bench.sv
module ide_addr_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] PRESENT = 4'b0111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, err_flag;
  logic [31:0] rsp_rdata;
  logic drv_valid, drv_write, drv_ctrl;
  logic [1:0] drv_idx;
  logic [3:0] drv_offset;
  logic [15:0] drv_wdata, drv_rdata;
  logic bm_valid, bm_write, bm_chan;
  logic [3:0] bm_offset;
  logic [1:0] bm_size;
  logic [31:0] bm_wdata, bm_rdata;
  logic [7:0] beat = 8'h00;

  int checks = 0;
  int errors = 0;

  int m_base[5];
  bit m_io, m_bm, m_err;
  bit m_dev[2];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (drv_valid) beat <= beat + 8'h01;

  assign drv_rdata = {4'hD, 2'b00, drv_idx, beat};
  assign bm_rdata  = 32'hB000_0000 | {28'h0, bm_offset};

  ide_addr_router u_ide_addr_router (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .err_flag(err_flag), .drv_present(PRESENT), .drv_valid(drv_valid),
    .drv_write(drv_write), .drv_idx(drv_idx), .drv_ctrl(drv_ctrl),
    .drv_offset(drv_offset), .drv_wdata(drv_wdata), .drv_rdata(drv_rdata),
    .bm_valid(bm_valid), .bm_write(bm_write), .bm_chan(bm_chan),
    .bm_offset(bm_offset), .bm_size(bm_size), .bm_wdata(bm_wdata),
    .bm_rdata(bm_rdata)
  );

  task automatic chk(input string tag, input string what, input int k,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual=%h expected=%h", tag, what, k, act, exp);
    end
  endtask

  function automatic int span_of(input int i);
    return (i == 4) ? 16 : ((i % 2) == 1) ? 4 : 8;
  endfunction

  task automatic cfg(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
    if (sel < 3'd5) begin
      if (d != 16'h0) m_base[sel] = int'(d);
    end else if (sel == 3'd5) begin
      m_io = d[0];
      m_bm = d[2];
    end
  endtask

  task automatic run(input string tag, input bit wr, input logic [15:0] a,
                     input logic [1:0] sz, input logic [31:0] wd);
    int w, ofs, ch, idx, lat;
    bit cmdw, ctlw, bmw, dport, szok, loc, dbl, errev;
    bit e_rsp, e_drv, e_bm;
    logic [7:0] b0;
    logic [31:0] exp_rd;
    logic [15:0] exp_wd;
    w = 5; ofs = 0; b0 = 8'h00;
    for (int i = 0; i < 5; i++) begin
      if (w == 5 && int'(a) >= m_base[i] && int'(a) < m_base[i] + span_of(i)) begin
        w = i;
        ofs = int'(a) - m_base[i];
      end
    end
    cmdw  = (w == 0 || w == 2);
    ctlw  = (w == 1 || w == 3);
    bmw   = (w == 4);
    ch    = (w == 2 || w == 3 || (w == 4 && ofs >= 8)) ? 1 : 0;
    dport = cmdw && ofs == 0;
    szok  = bmw ? (sz != 2'd3) : dport ? (sz == 2'd1 || sz == 2'd2) : (sz == 2'd0);
    if (m_io && cmdw && ofs == 6 && wr && szok) m_dev[ch] = wd[4];
    idx   = 2 * ch + int'(m_dev[ch]);
    errev = (w == 5) || (m_io && !szok);
    loc   = (w == 5) || !m_io || !szok || (bmw && wr && !m_bm) ||
            (!bmw && !PRESENT[idx]);
    if (errev) m_err = 1'b1;
    dbl   = dport && sz == 2'd2;
    lat   = loc ? 1 : bmw ? 2 : dbl ? 3 : 2;

    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= lat; k++) begin
      if (k > 1) @(negedge clk);
      if (k == 1) b0 = beat;
      e_rsp = (k == lat);
      e_drv = !loc && !bmw && (k < lat);
      e_bm  = !loc && bmw && (k == 1);
      // R12: ready, response timing and sticky error visible per cycle
      chk(tag, "ready/rsp/drv/bm/err (R12)", k,
          {59'h0, req_ready, rsp_valid, drv_valid, bm_valid, err_flag},
          {59'h0, e_rsp, e_rsp, e_drv, e_bm, m_err});
      if (e_drv) begin
        exp_wd = (sz == 2'd0) ? {8'h00, wd[7:0]} : (k == 1) ? wd[15:0] : wd[31:16];
        chk(tag, "drive fields", k,
            {40'h0, drv_write, drv_idx, drv_ctrl, drv_offset, drv_wdata},
            {40'h0, wr, 2'(idx), ctlw, 4'(ofs), exp_wd});
      end
      if (e_bm) begin
        chk(tag, "bus-master fields", k,
            {24'h0, bm_write, bm_chan, bm_offset, bm_size, bm_wdata},
            {24'h0, wr, 1'(ch), 4'(ofs), sz, wd});
      end
      if (e_rsp) begin
        if (wr || loc)        exp_rd = 32'h0;
        else if (bmw)         exp_rd = 32'hB000_0000 | 32'(ofs);
        else if (dbl)         exp_rd = {4'hD, 2'b00, 2'(idx), b0 + 8'h01, 4'hD, 2'b00, 2'(idx), b0};
        else if (sz == 2'd0)  exp_rd = {24'h0, b0};
        else                  exp_rd = {16'h0, 4'hD, 2'b00, 2'(idx), b0};
        chk(tag, "read data", k, {32'h0, rsp_rdata}, {32'h0, exp_rd});
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) m_base[i] = 0;
    m_io = 0; m_bm = 0; m_err = 0; m_dev[0] = 0; m_dev[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk("R12", "reset ready/rsp/drv/bm/err", 0,
        {59'h0, req_ready, rsp_valid, drv_valid, bm_valid, err_flag},
        {59'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0});

    run("R6", 1'b0, 16'h0001, 2'd0, 32'h0);          // I/O off: local zero
    cfg(3'd0, 16'h01F0);
    cfg(3'd1, 16'h03F4);
    cfg(3'd2, 16'h0170);
    cfg(3'd3, 16'h0374);
    cfg(3'd4, 16'hC000);
    cfg(3'd2, 16'h0000);                             // R4: zero base ignored
    cfg(3'd5, 16'h0001);                             // R5: I/O only
    run("R4", 1'b0, 16'h0171, 2'd0, 32'h0);
    run("R7", 1'b1, 16'hC000, 2'd0, 32'h0000_0001);  // bm disabled: dropped
    run("R3", 1'b0, 16'hC00A, 2'd0, 32'h0);          // secondary half
    run("R3", 1'b0, 16'hC002, 2'd1, 32'h0);          // primary half
    run("R3", 1'b0, 16'hC008, 2'd0, 32'h0);          // exact split offset
    cfg(3'd5, 16'h0005);
    run("R5", 1'b1, 16'hC004, 2'd2, 32'h1234_5678);
    run("R1", 1'b0, 16'h03F6, 2'd0, 32'h0);          // primary control
    run("R8", 1'b1, 16'h01F6, 2'd0, 32'h0000_0010);  // select slave on ch0
    run("R9", 1'b0, 16'h01F0, 2'd1, 32'h0);
    run("R9", 1'b0, 16'h01F0, 2'd2, 32'h0);
    run("R11", 1'b1, 16'h0176, 2'd0, 32'h0000_0010); // slave ch1 absent
    run("R11", 1'b0, 16'h0177, 2'd0, 32'h0);
    run("R8", 1'b1, 16'h0176, 2'd0, 32'h0000_0000);  // back to master ch1
    run("R9", 1'b1, 16'h0170, 2'd2, 32'hCAFE_BEEF);
    cfg(3'd1, 16'h01F4);                             // overlap with cmd window
    run("R1", 1'b0, 16'h01F5, 2'd0, 32'h0);
    cfg(3'd5, 16'h0004);                             // R5: re-evaluated, I/O off
    run("R6", 1'b1, 16'h01F6, 2'd0, 32'h0000_0000);
    cfg(3'd5, 16'h0005);
    run("R6", 1'b0, 16'h01F0, 2'd1, 32'h0);          // still slave on ch0
    run("R10", 1'b0, 16'h01F1, 2'd1, 32'h0);
    run("R10", 1'b0, 16'h01F0, 2'd0, 32'h0);
    run("R10", 1'b0, 16'hC003, 2'd3, 32'h0);
    run("R2", 1'b0, 16'h5000, 2'd0, 32'h0);
    run("R2", 1'b0, 16'h01F0, 2'd1, 32'h0);          // error stays set

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule